// File: doc/BRIEF.md
# Two-Phase Transition Handshake Link

This block is a matched sender and receiver pair that carries data words across a bundled-data channel using transition signalling. A request is any change of level on the request line, and an acknowledge is any change of level on the acknowledge line. Both rising and falling edges count. A complete transfer therefore takes exactly two wire transitions, one on each line, and there is no return-to-zero phase. The channel is a push channel: the sender starts every transfer.

Words enter on a local valid/ready stream at the sender and leave on a local valid/ready stream at the receiver. A word is taken on a cycle where `src_valid` and `src_ready` are both high. A word is delivered on a cycle where `dst_valid` and `dst_ready` are both high. Back-pressure works as follows. While the downstream consumer holds `dst_ready` low, the receiver keeps the word and its acknowledge level unchanged. The sender then stays busy and holds `src_ready` low until the acknowledge transition comes back.

Both ends run from one clock. Each end finds an event by comparing the incoming line with a stored copy of its previous level. A parameter `WIRE_STAGES` inserts register stages on the forward path (request line and data, delayed together) and on the return path (acknowledge line), so the link can be tested with flight time on the wires. After reset both lines are 0, their levels are equal, and the link is idle.

Top module: `tp_link`

## Requirements
- R1: After reset, `link_req` and `link_ack` are 0, `src_ready` is 1 and `dst_valid` is 0.
- R2: Each word accepted on the source stream toggles the sender's request level exactly once. Rising and falling edges both count as requests. The request level does not change on any other cycle.
- R3: While a transfer is outstanding (`src_ready` low), the word the sender drives onto the channel data stays stable.
- R4: The sender holds `src_ready` low, and raises no new request, from the cycle after it accepts a word until the acknowledge transition for that word has been seen.
- R5: The receiver presents a word on `dst_valid`/`dst_data` when the request level it has seen differs from its own acknowledge level. Words arrive unchanged and in the order they were sent.
- R6: While `dst_valid` is high and `dst_ready` is low, `dst_valid` stays high and `dst_data` stays stable on the next cycle.
- R7: The receiver toggles its acknowledge level exactly once per word delivered on the destination stream, and at no other time. The number of request-line transitions therefore equals the number of acknowledge-line transitions, which equals the number of words delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends of the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source word is valid |
| src_ready | output | 1 | Sender can take a word (no transfer outstanding) |
| src_data | input | DATA_W | Source word |
| dst_valid | output | 1 | Receiver holds an undelivered word |
| dst_ready | input | 1 | Consumer takes the word |
| dst_data | output | DATA_W | Delivered word |
| link_req | output | 1 | Request line level as it arrives at the receiver |
| link_ack | output | 1 | Acknowledge line level as it arrives at the sender |
| link_data | output | DATA_W | Channel data as it arrives at the receiver |

## Verification
The link is driven with three input patterns. A back-to-back burst with the consumer always ready shows that the sender waits for each acknowledge, and that rising and falling requests are both taken. Alternating all-zero and all-one words show that the data captured at the receiver is the bundled word and not a stale one. Pseudo-random words with a toggling `dst_ready` mix request edges with back-pressure. A held stall, where a second word waits at the source while the consumer refuses the first, separates correct blocking of the sender from lost or duplicated transfers. Counting the transitions on both lines against the delivered words confirms that each transfer uses two transitions and has no return-to-zero phase.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Two line levels that differ mark an event that has not been answered yet.
  function automatic logic level_differs(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/tp_wire_delay.sv
module tp_wire_delay #(
  parameter int W      = 1,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage_q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else if (i == 0) stage_q[i] <= din;
          else stage_q[i] <= stage_q[(i > 0) ? i-1 : 0];
        end
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tp_sender.sv
module tp_sender
  import tp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              ack_in,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out
);
  logic              req_q;
  logic              ack_seen_q;
  logic [DATA_W-1:0] data_q;
  logic              busy;
  logic              take;

  assign busy      = level_differs(req_q, ack_seen_q);
  assign src_ready = !busy;
  assign take      = src_valid && src_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      data_q     <= '0;
    end else begin
      ack_seen_q <= ack_in;
      if (take) begin
        data_q <= src_data;
        req_q  <= ~req_q;
      end
    end
  end

  assign req_out  = req_q;
  assign data_out = data_q;
endmodule

// File: rtl/tp_receiver.sv
module tp_receiver
  import tp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_out,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_seen_q;
  logic              ack_q;
  logic [DATA_W-1:0] hold_q;
  logic              new_edge;
  logic              pending;

  assign new_edge  = level_differs(req_in, req_seen_q);
  assign pending   = level_differs(req_seen_q, ack_q);
  assign dst_valid = pending;
  assign dst_data  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      hold_q     <= '0;
    end else begin
      req_seen_q <= req_in;
      if (new_edge) hold_q <= data_in;
      if (pending && dst_ready) ack_q <= ~ack_q;
    end
  end

  assign ack_out = ack_q;
endmodule

// File: rtl/tp_link.sv
module tp_link #(
  parameter int DATA_W      = 16,
  parameter int WIRE_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              link_req,
  output logic              link_ack,
  output logic [DATA_W-1:0] link_data
);
  localparam int FWD_W = DATA_W + 1;

  logic              snd_req;
  logic [DATA_W-1:0] snd_data;
  logic              rcv_ack;
  logic [FWD_W-1:0]  fwd_far;

  tp_sender #(.DATA_W(DATA_W)) u_sender (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .ack_in(link_ack), .req_out(snd_req), .data_out(snd_data)
  );

  tp_wire_delay #(.W(FWD_W), .STAGES(WIRE_STAGES)) u_fwd (
    .clk(clk), .rst_n(rst_n), .din({snd_req, snd_data}), .dout(fwd_far)
  );

  assign link_req  = fwd_far[FWD_W-1];
  assign link_data = fwd_far[DATA_W-1:0];

  tp_receiver #(.DATA_W(DATA_W)) u_receiver (
    .clk(clk), .rst_n(rst_n),
    .req_in(link_req), .data_in(link_data), .ack_out(rcv_ack),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data)
  );

  tp_wire_delay #(.W(1), .STAGES(WIRE_STAGES)) u_bwd (
    .clk(clk), .rst_n(rst_n), .din(rcv_ack), .dout(link_ack)
  );
endmodule

// File: rtl/tp_link_chk.sv
module tp_link_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic              dst_valid,
  input logic              dst_ready,
  input logic [DATA_W-1:0] dst_data,
  input logic              link_req,
  input logic              link_ack,
  input logic              snd_req,
  input logic [DATA_W-1:0] snd_data,
  input logic              rcv_ack
);
  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!link_req && !link_ack && src_ready && !dst_valid)); // R1
  AST_REQ_TOGGLE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (src_valid && src_ready) |=> (snd_req != $past(snd_req))); // R2
  AST_REQ_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n) !(src_valid && src_ready) |=> $stable(snd_req)); // R2
  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !src_ready |=> $stable(snd_data)); // R3
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (src_valid && src_ready) |=> !src_ready); // R4
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data))); // R6
  AST_ACK_ON_DELIVER: assert property (@(posedge clk) disable iff (!rst_n) (dst_valid && dst_ready) |=> (rcv_ack != $past(rcv_ack))); // R7
  AST_ACK_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n) !(dst_valid && dst_ready) |=> $stable(rcv_ack)); // R7
endmodule

bind tp_link tp_link_chk #(.DATA_W(DATA_W)) u_tp_link_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
  .link_req(link_req), .link_ack(link_ack),
  .snd_req(snd_req), .snd_data(snd_data), .rcv_ack(rcv_ack)
);

// File: tb/tp_link_bench.sv
`timescale 1ns/1ps
module tp_link_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [DW-1:0] src_data = '0;
  logic          dst_valid;
  logic          dst_ready = 1'b0;
  logic [DW-1:0] dst_data;
  logic          link_req, link_ack;
  logic [DW-1:0] link_data;

  tp_link #(.DATA_W(DW), .WIRE_STAGES(1)) u_tp_link (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready),
    .dst_data(dst_data), .link_req(link_req), .link_ack(link_ack),
    .link_data(link_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int n_sent = 0, n_got = 0, req_tog = 0, ack_tog = 0, busy_run = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] prev_link_data;
  logic prev_req = 1'b0, prev_ack = 1'b0, mon_on = 1'b0;
  int ready_mode = 0; // 0 always, 1 never, 2 alternate
  int rcnt = 0;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic send(input logic [DW-1:0] w);
    @(negedge clk);
    src_valid = 1'b1;
    src_data  = w;
    while (!src_ready) @(negedge clk);
    q.push_back(w);
    n_sent++;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  // monitor: scoreboard, line transitions, bus stability
  always @(negedge clk) begin
    rcnt++;
    case (ready_mode)
      0: dst_ready = 1'b1;
      1: dst_ready = 1'b0;
      default: dst_ready = rcnt[0];
    endcase
    if (mon_on) begin
      if (link_req != prev_req) req_tog++;
      if (link_ack != prev_ack) ack_tog++;
      prev_req = link_req;
      prev_ack = link_ack;
      if (busy_run >= 2) chk(link_data == prev_link_data, "R3 bus data stable", link_data, prev_link_data);
      busy_run = src_ready ? 0 : busy_run + 1;
      prev_link_data = link_data;
      if (dst_valid && dst_ready) begin
        if (q.size() == 0) chk(1'b0, "R5 unexpected word", dst_data, '0);
        else begin
          logic [DW-1:0] e;
          e = q.pop_front();
          chk(dst_data == e, "R5 word order/value", dst_data, e);
        end
        n_got++;
      end
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", '0, '0);
        finish_run();
      end
    end
  end

  initial begin
    logic [DW-1:0] lfsr;
    logic ack_hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_req == 1'b0, "R1 link_req", {15'd0, link_req}, 0);
    chk(link_ack == 1'b0, "R1 link_ack", {15'd0, link_ack}, 0);
    chk(src_ready == 1'b1, "R1 src_ready", {15'd0, src_ready}, 1);
    chk(dst_valid == 1'b0, "R1 dst_valid", {15'd0, dst_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // burst, consumer always ready: rising and falling requests (R2, R5)
    ready_mode = 0;
    for (int i = 0; i < 10; i++) send(16'h1000 + DW'(i));
    // alternating extreme values (R5)
    for (int i = 0; i < 8; i++) send(i[0] ? 16'hFFFF : 16'h0000);
    // random words with toggling consumer (R5, R6)
    ready_mode = 2;
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr);
    end
    repeat (20) @(negedge clk);

    // held stall: R4, R6, R7
    ready_mode = 1;
    send(16'h5A5A);
    repeat (6) @(negedge clk);
    ack_hold = link_ack;
    src_valid = 1'b1;
    src_data  = 16'hC3C3;
    repeat (20) @(negedge clk);
    chk(src_ready == 1'b0, "R4 sender blocked", {15'd0, src_ready}, 0);
    chk(dst_valid == 1'b1, "R6 word held", {15'd0, dst_valid}, 1);
    chk(dst_data == 16'h5A5A, "R6 data held", dst_data, 16'h5A5A);
    chk(link_ack == ack_hold, "R7 no ack under stall", {15'd0, link_ack}, {15'd0, ack_hold});
    chk(q.size() == 1, "R4 no second transfer", DW'(q.size()), 1);
    ready_mode = 0;
    while (!src_ready) @(negedge clk);
    q.push_back(16'hC3C3);
    n_sent++;
    @(negedge clk);
    src_valid = 1'b0;
    repeat (20) @(negedge clk);

    // totals: two transitions per transfer (R2, R7)
    chk(q.size() == 0, "R5 all delivered", DW'(q.size()), 0);
    chk(n_got == n_sent, "R5 delivered count", DW'(n_got), DW'(n_sent));
    chk(req_tog == n_sent, "R2 req transitions", DW'(req_tog), DW'(n_sent));
    chk(ack_tog == n_sent, "R7 ack transitions", DW'(ack_tog), DW'(n_sent));
    chk(src_ready && !dst_valid, "R7 idle after last ack", {14'd0, src_ready, dst_valid}, 16'h2);
    finish_run();
  end
endmodule